// File: doc/BRIEF.md
# Multi-Format Serial Stereo Audio Receiver

This block takes a serial stereo stream made of a bit clock, a frame clock and one data line, and turns it into parallel left and right samples of 24 bits each, presented together with a one-cycle valid strobe once per frame. It runs entirely on the bit clock: every register samples the frame clock and the data line on the rising bit-clock edge. A two-bit select input picks the layout of the word inside each half-frame. The choices are I2S, MSB-justified at 24 bits, and LSB-justified at 16 or 24 bits. Frame rates from 8 kHz up to 192 kHz are covered, because nothing in the block depends on the absolute rate.

Each half-frame holds `SLOT_BITS` bit clocks. In this description, "slot position p" means the p-th bit sampled in a half-frame. Position 0 is the first rising edge at which the frame clock shows its new level. Words that are 16 bits wide come out in the upper bits of the 24-bit output, and the low byte is zero. The block starts receiving only after it has seen a frame-clock transition. It emits a pair only when a left word has come before the right word.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` is decoded as follows: 2'b00 is 16-bit LSB-justified, 2'b01 is 24-bit LSB-justified, 2'b10 is 24-bit MSB-justified, and 2'b11 is I2S.
- R2: In 16-bit LSB-justified mode, slot positions 16 to 31 carry the word, MSB first. The output is {word, 8'h00}.
- R3: In 24-bit LSB-justified mode, slot positions 8 to 31 carry the word, MSB first. The last bit of the half-frame is the LSB.
- R4: In 24-bit MSB-justified mode, slot positions 0 to 23 carry the word, MSB first. Positions 24 to 31 are ignored.
- R5: In I2S mode, the MSB is at slot position 1 and the LSB at position 24. A frame clock held low marks the left channel.
- R6: In all three justified modes, a frame clock held high marks the left channel and a low level marks the right channel.
- R7: `pair_valid` is high for exactly one bit clock. It rises on the edge after the one that samples the right word's LSB. `left_out` and `right_out` change only together with `pair_valid`.
- R8: No pair is produced before the first frame-clock transition seen after reset. A right word that has no left word received before it since the last pair is discarded.
- R9: The format is captured at slot position 0 of each half-frame. A change of `fmt_sel` later in that half-frame has no effect on the word being received.
- R10: During reset `left_out` and `right_out` are zero and `pair_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low reset |
| frame_clk | input | 1 | Frame (channel select) clock |
| sdata | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Word layout select (R1) |
| left_out | output | 24 | Left sample of the latest pair |
| right_out | output | 24 | Right sample of the latest pair |
| pair_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The bench builds the block with its defaults: 32 bit clocks per half-frame, 24-bit output words and 16-bit short words. With these values all four layouts can be placed at their real slot positions, including the LSB-justified windows that end on the last bit of the half-frame. With a 32-bit slot, the right word's LSB falls at position 31, 23 or 24 depending on the mode, so the strobe timing is checked at three different distances from the next frame-clock edge. A reset followed by I2S traffic starts on a half-frame that has no edge before it, which exercises the rule that a right word without a left word is dropped.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    // Word layout codes; the numeric values are the fmt_sel encoding (R1)
    typedef enum logic [1:0] {
        FMT_LSB16 = 2'b00,
        FMT_LSB24 = 2'b01,
        FMT_MSB24 = 2'b10,
        FMT_I2S   = 2'b11
    } fmt_e;

    // Number of data bits carried in a half-frame for a layout
    function automatic int unsigned fmt_len(fmt_e f, int unsigned word_w,
                                            int unsigned short_w);
        return (f == FMT_LSB16) ? short_w : word_w;
    endfunction

    // Slot position of the MSB for a layout
    function automatic int unsigned fmt_start(fmt_e f, int unsigned slot_bits,
                                              int unsigned word_w,
                                              int unsigned short_w);
        int unsigned s;
        case (f)
            FMT_LSB16: s = slot_bits - short_w;
            FMT_LSB24: s = slot_bits - word_w;
            FMT_MSB24: s = 0;
            default:   s = 1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sarx_frame_track.sv
module sarx_frame_track
    import sarx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned POS_W     = $clog2(SLOT_BITS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic [1:0]       fmt_sel,
    output logic [POS_W-1:0] bit_pos,
    output fmt_e             cur_fmt,
    output logic             cur_left,
    output logic             bit_ok
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic             fc;
        logic             seen;
        logic             locked;
        logic [POS_W-1:0] pos;
        logic             left;
        fmt_e             fmt;
    } trk_t;

    trk_t trk_q, trk_d;
    logic fc_edge;

    always_comb begin
        trk_d      = trk_q;
        trk_d.fc   = frame_clk;
        trk_d.seen = 1'b1;
        fc_edge    = trk_q.seen && (frame_clk != trk_q.fc);
        if (fc_edge) begin
            // first bit of a new half-frame: restart the slot count and
            // take the format and channel for the whole half-frame
            trk_d.pos    = '0;
            trk_d.locked = 1'b1;
            trk_d.fmt    = fmt_e'(fmt_sel);
            trk_d.left   = (fmt_e'(fmt_sel) == FMT_I2S) ? ~frame_clk : frame_clk;
        end else if (trk_q.pos != POS_MAX) begin
            trk_d.pos = trk_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{fc: 1'b0, seen: 1'b0, locked: 1'b0, pos: POS_MAX,
                       left: 1'b0, fmt: FMT_LSB16};
        end else begin
            trk_q <= trk_d;
        end
    end

    // position, format and channel of the bit sampled on this edge
    assign bit_pos  = trk_d.pos;
    assign cur_fmt  = trk_d.fmt;
    assign cur_left = trk_d.left;
    assign bit_ok   = trk_d.locked;

endmodule

// File: rtl/sarx_word_shift.sv
module sarx_word_shift
    import sarx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned WORD_W    = 24,
    parameter int unsigned SHORT_W   = 16,
    parameter int unsigned POS_W     = $clog2(SLOT_BITS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  bit_pos,
    input  fmt_e              cur_fmt,
    input  logic              bit_ok,
    input  logic              sdata,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned SHIFT_W = WORD_W - 1;
    localparam int unsigned PAD_W   = WORD_W - SHORT_W;

    typedef struct packed {
        logic [SHIFT_W-1:0] sh;
    } shf_t;

    shf_t        shf_q, shf_d;
    int unsigned pos_u;
    int unsigned win_lo;
    int unsigned win_len;
    logic        in_win;

    always_comb begin
        shf_d   = shf_q;
        pos_u   = {{(32-POS_W){1'b0}}, bit_pos};
        win_lo  = fmt_start(cur_fmt, SLOT_BITS, WORD_W, SHORT_W);
        win_len = fmt_len(cur_fmt, WORD_W, SHORT_W);
        in_win  = bit_ok && (pos_u >= win_lo) && (pos_u < win_lo + win_len);
        if (in_win) begin
            shf_d.sh = {shf_q.sh[SHIFT_W-2:0], sdata};
        end
        word_done = in_win && (pos_u == win_lo + win_len - 1);
        if (win_len == WORD_W) begin
            word = {shf_q.sh, sdata};
        end else begin
            word = {shf_q.sh[SHORT_W-2:0], sdata, {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

endmodule

// File: rtl/sarx_pair_out.sv
module sarx_pair_out #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              cur_left,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              pair_valid
);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              have_left;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic              valid;
    } pair_t;

    pair_t pr_q, pr_d;

    always_comb begin
        pr_d       = pr_q;
        pr_d.valid = 1'b0;
        if (word_done) begin
            if (cur_left) begin
                pr_d.hold      = word;
                pr_d.have_left = 1'b1;
            end else if (pr_q.have_left) begin
                pr_d.left      = pr_q.hold;
                pr_d.right     = word;
                pr_d.valid     = 1'b1;
                pr_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign left_out   = pr_q.left;
    assign right_out  = pr_q.right;
    assign pair_valid = pr_q.valid;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned WORD_W    = 24,
    parameter int unsigned SHORT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic              sdata,
    input  logic [1:0]        fmt_sel,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              pair_valid
);

    localparam int unsigned POS_W = $clog2(SLOT_BITS) + 1;

    logic [POS_W-1:0]  bit_pos;
    fmt_e              cur_fmt;
    logic              cur_left;
    logic              bit_ok;
    logic              word_done;
    logic [WORD_W-1:0] word;

    sarx_frame_track #(
        .SLOT_BITS(SLOT_BITS),
        .POS_W    (POS_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_clk(frame_clk),
        .fmt_sel  (fmt_sel),
        .bit_pos  (bit_pos),
        .cur_fmt  (cur_fmt),
        .cur_left (cur_left),
        .bit_ok   (bit_ok)
    );

    sarx_word_shift #(
        .SLOT_BITS(SLOT_BITS),
        .WORD_W   (WORD_W),
        .SHORT_W  (SHORT_W),
        .POS_W    (POS_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_pos  (bit_pos),
        .cur_fmt  (cur_fmt),
        .bit_ok   (bit_ok),
        .sdata    (sdata),
        .word_done(word_done),
        .word     (word)
    );

    sarx_pair_out #(
        .WORD_W(WORD_W)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .cur_left  (cur_left),
        .left_out  (left_out),
        .right_out (right_out),
        .pair_valid(pair_valid)
    );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int unsigned WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_valid,
    input logic [WORD_W-1:0] left_out,
    input logic [WORD_W-1:0] right_out,
    input logic              bit_ok,
    input logic [1:0]        fmt_now
);

    // R7: the strobe never lasts two bit clocks
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7: outputs move only together with the strobe
    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    // R8: nothing is emitted before the receiver has aligned to the frame clock
    a_r8_no_pair_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ok |-> !pair_valid);

    // R2: a right word taken in 16-bit mode has a zero low byte
    a_r2_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && ($past(fmt_now) == 2'b00)) |-> (right_out[7:0] == 8'h00));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_valid(pair_valid),
    .left_out  (left_out),
    .right_out (right_out),
    .bit_ok    (bit_ok),
    .fmt_now   (cur_fmt)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 32;
    localparam int NVEC       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_out, right_out;
    logic        pair_valid;

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .sdata(sdata),
        .fmt_sel(fmt_sel), .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference state built from the requirements
    logic        prev_lvl = 1'b0;
    logic        m_locked = 1'b0;
    logic        m_left_ok = 1'b0;
    logic        exp_valid = 1'b0;
    logic [23:0] exp_l = '0, exp_r = '0, pend_l = '0;
    string       exp_tag = "R7";

    // {fmt, left, right}; justified layouts only
    localparam logic [49:0] VEC [NVEC] = '{
        {2'b10, 24'hA5C3F1, 24'h1E2D3C},
        {2'b01, 24'h800001, 24'h7FFFFE},
        {2'b00, 24'hFFFF00, 24'h0001AB},
        {2'b10, 24'hFFFFFF, 24'h000000},
        {2'b01, 24'h000001, 24'h800000},
        {2'b00, 24'h8001CD, 24'h7FFE12}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    // one bit clock: check the strobe from the previous edge, then drive
    task automatic drive_bit(input logic lvl, input logic d, input logic [1:0] f);
        @(negedge clk);
        check(pair_valid === exp_valid, "R7/R8", "pair_valid",
              {23'b0, pair_valid}, {23'b0, exp_valid});
        if (exp_valid) begin
            check(left_out === exp_l, exp_tag, "left_out", left_out, exp_l);
            check(right_out === exp_r, exp_tag, "right_out", right_out, exp_r);
        end
        exp_valid = 1'b0;
        frame_clk = lvl;
        sdata     = d;
        fmt_sel   = f;
    endtask

    task automatic send_half(input logic [1:0] f, input logic [23:0] w,
                             input logic lvl, input bit is_left, input bit glitch,
                             input string tag);
        int  lo, len;
        bit  half_ok;
        logic [23:0] ew;
        lo  = (f == 2'b00) ? SLOT-16 : (f == 2'b01) ? SLOT-24 : (f == 2'b10) ? 0 : 1;
        len = (f == 2'b00) ? 16 : 24;
        ew  = (f == 2'b00) ? {w[23:8], 8'h00} : w;
        if (lvl != prev_lvl) m_locked = 1'b1;
        half_ok  = m_locked;
        prev_lvl = lvl;
        for (int p = 0; p < SLOT; p++) begin
            logic d;
            logic [1:0] fd;
            d  = (p >= lo && p < lo + len) ? w[23 - (p - lo)] : 1'b0;
            fd = (glitch && p >= 4) ? ~f : f;
            drive_bit(lvl, d, fd);
            if (p == lo + len - 1 && half_ok) begin
                if (is_left) begin
                    pend_l    = ew;
                    m_left_ok = 1'b1;
                end else if (m_left_ok) begin
                    exp_valid = 1'b1;
                    exp_l     = pend_l;
                    exp_r     = ew;
                    exp_tag   = tag;
                    m_left_ok = 1'b0;
                end
            end
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input logic [23:0] l,
                              input logic [23:0] r, input bit glitch,
                              input string tag);
        logic left_lvl;
        left_lvl = (f == 2'b11) ? 1'b0 : 1'b1;
        send_half(f, l, left_lvl, 1, glitch, tag);
        send_half(f, r, ~left_lvl, 0, glitch, tag);
    endtask

    task automatic do_reset();
        drive_bit(prev_lvl, 1'b0, fmt_sel);
        rst_n     = 1'b0;
        frame_clk = 1'b0;
        sdata     = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(left_out === 24'h0, "R10", "left_out in reset", left_out, 24'h0);
        check(right_out === 24'h0, "R10", "right_out in reset", right_out, 24'h0);
        check(pair_valid === 1'b0, "R10", "pair_valid in reset",
              {23'b0, pair_valid}, 24'h0);
        rst_n     = 1'b1;
        prev_lvl  = 1'b0;
        m_locked  = 1'b0;
        m_left_ok = 1'b0;
        exp_valid = 1'b0;
        repeat (2) drive_bit(1'b0, 1'b0, fmt_sel);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // table walk: R1 decoding, R2/R3/R4 windows, R6 channel polarity
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] f;
            string tag;
            f   = VEC[i][49:48];
            tag = (f == 2'b00) ? "R1/R2/R6" : (f == 2'b01) ? "R1/R3/R6" : "R1/R4/R6";
            send_frame(f, VEC[i][47:24], VEC[i][23:0], 0, tag);
        end
        // R9: fmt_sel changed inside each half-frame is ignored
        send_frame(2'b01, 24'h3C5A96, 24'hC3A569, 1, "R9");
        send_frame(2'b10, 24'h123456, 24'h654321, 1, "R9");
        send_frame(2'b00, 24'hBEEF00, 24'h4AA500, 1, "R9");

        // R8/R5: after reset the first I2S half has no edge, so no pair
        do_reset();
        send_frame(2'b11, 24'h111111, 24'h222222, 0, "R5");
        send_frame(2'b11, 24'hF00F0F, 24'h0FF0F0, 0, "R1/R5");
        send_frame(2'b11, 24'h800000, 24'h000001, 0, "R5");
        send_frame(2'b11, 24'h5A5A5A, 24'hA5A5A5, 1, "R9/R5");
        drive_bit(1'b0, 1'b0, 2'b11);

        // R7: outputs hold the last pair while idle
        repeat (5) drive_bit(1'b0, 1'b0, 2'b11);
        check(left_out === 24'h5A5A5A, "R7", "left_out held", left_out, 24'h5A5A5A);
        check(right_out === 24'hA5A5A5, "R7", "right_out held", right_out, 24'hA5A5A5);
        report();
    end

endmodule